// File: doc/BRIEF.md
# Source Field Extract and Combine Unit

This block is the combinational data path of a small 8-bit controller, with one registered status bit. Each operation picks a source byte. A register-file source is used as it is. An I/O-bus source is rotated right and then trimmed to a field of a chosen width, which starts at bit 0. The prepared value is then combined with an auxiliary accumulator byte by one of four operations: pass-through, add, bitwise AND or bitwise XOR. The 8-bit result leaves the block without any register.

An overflow flag records the carry out of the most significant bit of the last enabled add. The flag is held in a register with an asynchronous reset. All other operations leave it alone. The surrounding controller supplies the source byte from its register file or its bus port, and it takes `result` to wherever the destination is. When an I/O source is chosen, the `bus_side` output tells which of the two bus halves was addressed.

Top module: `srcx_alu`

## Requirements
- R1: When `src_code` bit 4 is 0 (a register source), the operand is `reg_data` without rotation or masking, and `field_len` has no effect. With opcode 0 (pass-through), `result` equals `reg_data`.
- R2: When `src_code` bit 4 is 1 (an I/O source, octal codes 20 to 37), the operand is `bus_data` rotated right by `src_code[2:0]` positions, from 0 to 7.
- R3: For an I/O source, a `field_len` of 1 to 7 keeps that many low bits of the rotated byte and clears every bit above them. A `field_len` of 0 keeps all 8 bits.
- R4: `bus_side` equals `src_code[3]` for I/O sources, so it is 0 for octal 20 to 27 and 1 for octal 30 to 37. It is 0 for register sources.
- R5: Opcode 1 (add) drives `result` with (operand + `aux_data`) mod 256.
- R6: Opcode 2 drives `result` with operand AND `aux_data`.
- R7: Opcode 3 drives `result` with operand XOR `aux_data`.
- R8: On a clock edge where `op_en` is 1 and the opcode is 1, `ovf` is loaded with the carry out of bit 7 of the addition.
- R9: On any other clock edge, `ovf` keeps its value. This covers opcodes 0, 2 and 3, and any edge where `op_en` is 0.
- R10: While `rst_n` is low, `ovf` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the overflow flag |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_en | input | 1 | Lets an add update the flag on this edge |
| opcode | input | 2 | 0 pass, 1 add, 2 AND, 3 XOR |
| src_code | input | 5 | Source selector; bit 4 selects I/O, bit 3 selects bus side, bits 2:0 give the rotate amount |
| field_len | input | 3 | Width of the kept I/O field; 0 keeps all bits |
| reg_data | input | 8 | Register-file source byte |
| bus_data | input | 8 | I/O-bus source byte |
| aux_data | input | 8 | Auxiliary accumulator byte |
| result | output | 8 | Combined result |
| ovf | output | 1 | Registered carry flag of the last enabled add |
| bus_side | output | 1 | Bus half addressed by an I/O source |

## Verification
The bench builds the default 8-bit data path once with the staged rotator and once with the direct rotator. This means both generate variants are checked against the same arithmetic model. At this width the whole space of source codes, field lengths and opcodes is small enough to sweep in full. That sweep covers every rotate amount paired with every field width, and every register code combined with every length. Three data patterns and a varying enable pattern push the add through both carry outcomes. They also place flag-holding edges directly after flag-setting ones.

// File: rtl/srcx_pkg.sv
package srcx_pkg;
   typedef enum logic [1:0] {
      OP_PASS = 2'd0,
      OP_ADD  = 2'd1,
      OP_AND  = 2'd2,
      OP_XOR  = 2'd3
   } srcx_op_e;
endpackage

// File: rtl/srcx_rotr.sv
module srcx_rotr #(
   parameter int W     = 8,
   parameter int SH_W  = 3,
   parameter int STYLE = 0
) (
   input  logic [W-1:0]    din,
   input  logic [SH_W-1:0] amt,
   output logic [W-1:0]    dout
);
   generate
      if (STYLE == 0) begin : g_staged
         logic [W-1:0] stage [SH_W+1];
         assign stage[0] = din;
         for (genvar k = 0; k < SH_W; k++) begin : g_stage
            localparam int STEP = 1 << k;
            assign stage[k+1] = amt[k]
               ? {stage[k][STEP-1:0], stage[k][W-1:STEP]}
               : stage[k];
         end
         assign dout = stage[SH_W];
      end else begin : g_direct
         logic [2*W-1:0] doubled;
         always_comb begin
            doubled = {din, din} >> amt;
            dout    = doubled[W-1:0];
         end
      end
   endgenerate
endmodule

// File: rtl/srcx_fieldmask.sv
module srcx_fieldmask #(
   parameter int W     = 8,
   parameter int LEN_W = 3
) (
   input  logic [LEN_W-1:0] len,
   output logic [W-1:0]     mask
);
   generate
      for (genvar i = 0; i < W; i++) begin : g_bit
         localparam logic [LEN_W-1:0] IDX = LEN_W'(i);
         assign mask[i] = (len == '0) || (IDX < len);
      end
   endgenerate
endmodule

// File: rtl/srcx_opunit.sv
module srcx_opunit
   import srcx_pkg::*;
#(
   parameter int W = 8
) (
   input  srcx_op_e     op,
   input  logic [W-1:0] opa,
   input  logic [W-1:0] opb,
   output logic [W-1:0] res,
   output logic         carry
);
   logic [W:0] sum;
   always_comb begin
      sum   = {1'b0, opa} + {1'b0, opb};
      carry = sum[W];
      unique case (op)
         OP_PASS: res = opa;
         OP_ADD:  res = sum[W-1:0];
         OP_AND:  res = opa & opb;
         OP_XOR:  res = opa ^ opb;
         default: res = opa;
      endcase
   end
endmodule

// File: rtl/srcx_alu.sv
module srcx_alu
   import srcx_pkg::*;
#(
   parameter int DATA_W    = 8,
   parameter int ROT_STYLE = 0,
   localparam int ROT_W    = $clog2(DATA_W),
   localparam int CODE_W   = ROT_W + 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              op_en,
   input  logic [1:0]        opcode,
   input  logic [CODE_W-1:0] src_code,
   input  logic [ROT_W-1:0]  field_len,
   input  logic [DATA_W-1:0] reg_data,
   input  logic [DATA_W-1:0] bus_data,
   input  logic [DATA_W-1:0] aux_data,
   output logic [DATA_W-1:0] result,
   output logic              ovf,
   output logic              bus_side
);
   localparam int IO_BIT   = CODE_W - 1;
   localparam int SIDE_BIT = CODE_W - 2;

   generate
      if (DATA_W < 2 || (1 << ROT_W) != DATA_W) begin : g_bad_width
         $error("srcx_alu: DATA_W must be a power of two of at least 2");
      end
      if (ROT_STYLE != 0 && ROT_STYLE != 1) begin : g_bad_style
         $error("srcx_alu: ROT_STYLE must be 0 or 1");
      end
   endgenerate

   logic              is_io;
   logic [DATA_W-1:0] rotated;
   logic [DATA_W-1:0] fmask;
   logic [DATA_W-1:0] operand;
   logic              add_carry;
   srcx_op_e          op;

   assign is_io    = src_code[IO_BIT];
   assign bus_side = is_io & src_code[SIDE_BIT];
   assign op       = srcx_op_e'(opcode);

   srcx_rotr #(.W(DATA_W), .SH_W(ROT_W), .STYLE(ROT_STYLE)) rot_i (
      .din  (bus_data),
      .amt  (src_code[ROT_W-1:0]),
      .dout (rotated)
   );

   srcx_fieldmask #(.W(DATA_W), .LEN_W(ROT_W)) mask_i (
      .len  (field_len),
      .mask (fmask)
   );

   assign operand = is_io ? (rotated & fmask) : reg_data;

   srcx_opunit #(.W(DATA_W)) op_i (
      .op    (op),
      .opa   (operand),
      .opb   (aux_data),
      .res   (result),
      .carry (add_carry)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ovf <= 1'b0;
      end else if (op_en && op == OP_ADD) begin
         ovf <= add_carry;
      end
   end
endmodule

// File: rtl/srcx_alu_chk.sv
module srcx_alu_chk #(
   parameter int DATA_W    = 8,
   localparam int ROT_W    = $clog2(DATA_W),
   localparam int CODE_W   = ROT_W + 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              op_en,
   input logic [1:0]        opcode,
   input logic [CODE_W-1:0] src_code,
   input logic [ROT_W-1:0]  field_len,
   input logic [DATA_W-1:0] reg_data,
   input logic [DATA_W-1:0] bus_data,
   input logic [DATA_W-1:0] aux_data,
   input logic [DATA_W-1:0] result,
   input logic              ovf,
   input logic              bus_side
);
   assert_reg_pass_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (opcode == 2'd0 && !src_code[CODE_W-1]) |-> result == reg_data);

   assert_field_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (opcode == 2'd0 && src_code[CODE_W-1] && field_len != '0)
         |-> (result >> field_len) == '0);

   assert_side_io_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
      bus_side |-> src_code[CODE_W-1]);

   assert_and_subset_R6: assert property (@(posedge clk) disable iff (!rst_n)
      opcode == 2'd2 |-> (result & ~aux_data) == '0);

   assert_add_carry_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (op_en && opcode == 2'd1) |=> ovf == $past(result < aux_data));

   assert_flag_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !(op_en && opcode == 2'd1) |=> $stable(ovf));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         assert_reset_clear_R10: assert (ovf == 1'b0);
      end
   end
endmodule

bind srcx_alu srcx_alu_chk #(.DATA_W(DATA_W)) chk_i (.*);

// File: tb/srcx_alu_tb_top.sv
module srcx_alu_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       op_en = 1'b0;
   logic [1:0] opcode = 2'd0;
   logic [4:0] src_code = 5'd0;
   logic [2:0] field_len = 3'd0;
   logic [7:0] reg_data = 8'h00;
   logic [7:0] bus_data = 8'h00;
   logic [7:0] aux_data = 8'h00;
   logic [7:0] result_a, result_b;
   logic       ovf_a, ovf_b, side_a, side_b;

   int checks = 0;
   int errors = 0;
   bit exp_ovf = 1'b0;

   always #4 clk = ~clk;

   srcx_alu #(.DATA_W(8), .ROT_STYLE(0)) dut_i (
      .clk(clk), .rst_n(rst_n), .op_en(op_en), .opcode(opcode),
      .src_code(src_code), .field_len(field_len), .reg_data(reg_data),
      .bus_data(bus_data), .aux_data(aux_data), .result(result_a),
      .ovf(ovf_a), .bus_side(side_a));

   srcx_alu #(.DATA_W(8), .ROT_STYLE(1)) dut_direct_i (
      .clk(clk), .rst_n(rst_n), .op_en(op_en), .opcode(opcode),
      .src_code(src_code), .field_len(field_len), .reg_data(reg_data),
      .bus_data(bus_data), .aux_data(aux_data), .result(result_b),
      .ovf(ovf_b), .bus_side(side_b));

   task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h (code %o len %0d op %0d)",
                  tag, act, exp, src_code, field_len, opcode);
      end
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin : stim
      logic [15:0] dbl;
      logic [7:0]  mask, operand, exp_res;
      logic [8:0]  sum;
      string       tag;
      repeat (2) @(negedge clk);
      check("R10 ovf in reset", {7'd0, ovf_a}, 8'd0);
      check("R10 ovf in reset direct", {7'd0, ovf_b}, 8'd0);
      rst_n = 1'b1;
      for (int pat = 0; pat < 3; pat++) begin
         for (int code = 0; code < 32; code++) begin
            for (int len = 0; len < 8; len++) begin
               for (int op = 0; op < 4; op++) begin
                  @(negedge clk);
                  src_code  = 5'(code);
                  field_len = 3'(len);
                  opcode    = 2'(op);
                  op_en     = ((code + len + op + pat) % 5) != 0;
                  bus_data  = 8'hB4 ^ 8'(code * 7 + pat * 29);
                  reg_data  = 8'h5A + 8'(len * 17 + pat * 3);
                  aux_data  = 8'h9D ^ 8'(pat * 97 + op * 13 + code);
                  #1;
                  dbl  = {bus_data, bus_data} >> code[2:0];
                  mask = (len == 0) ? 8'hFF : (8'hFF >> (8 - len));
                  operand = code[4] ? (dbl[7:0] & mask) : reg_data;
                  sum = {1'b0, operand} + {1'b0, aux_data};
                  case (op)
                     0: begin exp_res = operand; tag = code[4] ? "R2 R3 rotate field" : "R1 register pass"; end
                     1: begin exp_res = sum[7:0]; tag = "R5 add"; end
                     2: begin exp_res = operand & aux_data; tag = "R6 and"; end
                     default: begin exp_res = operand ^ aux_data; tag = "R7 xor"; end
                  endcase
                  check(tag, result_a, exp_res);
                  check({tag, " direct"}, result_b, exp_res);
                  check("R4 bus side", {7'd0, side_a}, {7'd0, code[4] & code[3]});
                  if (op_en && op == 1) exp_ovf = sum[8];
                  @(posedge clk);
                  #1;
                  check((op_en && op == 1) ? "R8 carry flag" : "R9 flag hold",
                        {7'd0, ovf_a}, {7'd0, exp_ovf});
                  check("R8 R9 flag direct", {7'd0, ovf_b}, {7'd0, exp_ovf});
               end
            end
         end
      end
      @(negedge clk);
      rst_n = 1'b0;
      #1;
      check("R10 ovf on reset assert", {7'd0, ovf_a}, 8'd0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule